// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital core of a power supervisor. It takes already-digitized comparator results for a main supply, a second monitored supply and the battery-switch hysteresis window. From them it produces a stretched system reset, an undelayed low-line warning, a second-supply fail flag and the battery switchover control. A manual reset input is debounced against a millisecond tick, and the same tick times the reset stretch. One configuration bit picks a short or a long stretch.

All outputs are registered, so each follows its inputs after one clock edge. The analog comparison, the power path itself and the pad drivers sit outside the block. The battery-on flag drives the external switch. The backup-mode flag tells the bus logic to block communication.

Top module: `supply_seq`

## Requirements
- R1: While `main_ok` is 0, `rst_n_o` is 0 from the next clock edge. After `main_ok` returns to 1 with the manual reset released, `rst_n_o` goes to 1 on the clock edge that counts the stretch-length-th tick, and not before.
- R2: The stretch length is `SHORT_TICKS` (default 150) ticks when `por_long` is 0 and `LONG_TICKS` (default 800) ticks when `por_long` is 1.
- R3: `lowline_n` equals the value `main_ok` had one clock earlier, with no stretch.
- R4: `auxfail_n` equals the value `aux_ok` had one clock earlier, with no stretch.
- R5: While the debounced manual reset is active (low), `rst_n_o` is 0. After release is accepted, the full stretch of R1 and R2 runs again.
- R6: While `main_ok` is 1, `batt_on` is 0 from the next edge.
- R7: While `main_ok` is 0: `main_lt_batt` = 1 selects the battery, and otherwise `main_gt_batt` = 1 selects the main supply. When both are 0 the previous selection is kept. `main_lt_batt` wins if both are 1.
- R8: `backup` equals `batt_on` in every cycle.
- R9: A new level of `mr_n` is accepted only on the `DEB_TICKS`-th (default 16) consecutive tick at which `mr_n` differs from the accepted level. A tick at which it matches restarts the count.
- R10: During and right after synchronous reset, `rst_n_o`=0, `lowline_n`=0, `auxfail_n`=0, `batt_on`=0 and `backup`=0, the stretch count is cleared, and the manual reset is taken as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| main_ok | input | 1 | Main supply above its trip point |
| aux_ok | input | 1 | Second supply above its trip point |
| main_gt_batt | input | 1 | Main above battery plus margin |
| main_lt_batt | input | 1 | Main below battery minus margin |
| mr_n | input | 1 | Raw manual reset, active low |
| por_long | input | 1 | Stretch select: 0 short, 1 long |
| rst_n_o | output | 1 | System reset, active low |
| lowline_n | output | 1 | Low-line warning, active low |
| auxfail_n | output | 1 | Second-supply fail, active low |
| batt_on | output | 1 | Output rail taken from battery |
| backup | output | 1 | Backup mode, bus blocked |

## Verification
The bench counts the stretch exactly. An off-by-one counter would release reset a tick early or late at both stretch lengths. It holds the manual input low for one tick fewer than the debounce window and then for the full window. A debouncer that accepts early, or one that forgets to restart, would change reset at the wrong edge. It walks the battery selection through the hysteresis band and then raises `main_ok` with the low-margin flag still set. A switch that ignores the trip point would keep the battery on. Long random runs with rare supply drops and gapped ticks compare every output against a reference model in every cycle.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  typedef enum logic {SRC_MAIN = 1'b0, SRC_BATT = 1'b1} src_e;
endpackage

// File: rtl/mr_debounce.sv
module mr_debounce #(
  parameter int DEB_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic raw_n,
  output logic clean_n
);
  localparam int DW = $clog2(DEB_TICKS + 1);
  logic [DW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clean_n <= 1'b1;
      run_q   <= '0;
    end else if (tick_ms) begin
      if (raw_n == clean_n) begin
        run_q <= '0;
      end else if (run_q == DW'(DEB_TICKS - 1)) begin
        clean_n <= raw_n;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_DEB_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick_ms |=> $stable(clean_n)); // R9
endmodule

// File: rtl/reset_stretch.sv
module reset_stretch #(
  parameter int SHORT_TICKS = 150,
  parameter int LONG_TICKS  = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic hold,
  input  logic por_long,
  output logic rst_n_o
);
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = por_long ? CW'(LONG_TICKS - 1) : CW'(SHORT_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      rst_n_o <= 1'b0;
      cnt_q   <= '0;
    end else if (!rst_n_o && tick_ms) begin
      if (cnt_q >= last) begin
        rst_n_o <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_HOLD_FORCES_RESET: assert property (@(posedge clk) disable iff (rst)
    hold |=> !rst_n_o); // R5
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> ($past(tick_ms) && !$past(hold))); // R1
endmodule

// File: rtl/batt_switch.sv
module batt_switch
  import supply_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic main_ok,
  input  logic main_gt_batt,
  input  logic main_lt_batt,
  output logic batt_on,
  output logic backup
);
  src_e src_q;

  always_ff @(posedge clk) begin
    if (rst || main_ok)      src_q <= SRC_MAIN;
    else if (main_lt_batt)   src_q <= SRC_BATT;
    else if (main_gt_batt)   src_q <= SRC_MAIN;
  end

  assign batt_on = (src_q == SRC_BATT);
  assign backup  = batt_on;

  AST_BATT_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
    main_ok |=> !batt_on); // R6
  AST_BATT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(batt_on) |-> $past(main_lt_batt)); // R7
  AST_BATT_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(batt_on) |-> ($past(main_ok) || ($past(main_gt_batt) && !$past(main_lt_batt)))); // R7
endmodule

// File: rtl/supply_seq.sv
module supply_seq #(
  parameter int SHORT_TICKS = 150,
  parameter int LONG_TICKS  = 800,
  parameter int DEB_TICKS   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic main_ok,
  input  logic aux_ok,
  input  logic main_gt_batt,
  input  logic main_lt_batt,
  input  logic mr_n,
  input  logic por_long,
  output logic rst_n_o,
  output logic lowline_n,
  output logic auxfail_n,
  output logic batt_on,
  output logic backup
);
  logic mr_clean_n;

  mr_debounce #(.DEB_TICKS(DEB_TICKS)) i_deb (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .raw_n(mr_n), .clean_n(mr_clean_n)
  );

  reset_stretch #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) i_str (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .hold(!main_ok || !mr_clean_n),
    .por_long(por_long), .rst_n_o(rst_n_o)
  );

  batt_switch i_bsw (
    .clk(clk), .rst(rst), .main_ok(main_ok), .main_gt_batt(main_gt_batt),
    .main_lt_batt(main_lt_batt), .batt_on(batt_on), .backup(backup)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lowline_n <= 1'b0;
      auxfail_n <= 1'b0;
    end else begin
      lowline_n <= main_ok;
      auxfail_n <= aux_ok;
    end
  end

  AST_RESET_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    !main_ok |=> !rst_n_o); // R1
  AST_LOWLINE_LOW: assert property (@(posedge clk) disable iff (rst)
    !main_ok |=> !lowline_n); // R3
  AST_AUX_LOW: assert property (@(posedge clk) disable iff (rst)
    !aux_ok |=> !auxfail_n); // R4
  AST_BACKUP_MATCH: assert property (@(posedge clk) disable iff (rst)
    backup == batt_on); // R8
endmodule

// File: tb/test_supply_seq.sv
module test_supply_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_T = 150;
  localparam int LONG_T  = 800;
  localparam int DEB_T   = 16;

  logic clk = 0;
  logic rst = 1;
  logic tick_ms = 0, main_ok = 0, aux_ok = 0, main_gt_batt = 0, main_lt_batt = 0;
  logic mr_n = 1, por_long = 0;
  logic rst_n_o, lowline_n, auxfail_n, batt_on, backup;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  supply_seq i_supply_seq (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .main_ok(main_ok), .aux_ok(aux_ok),
    .main_gt_batt(main_gt_batt), .main_lt_batt(main_lt_batt), .mr_n(mr_n),
    .por_long(por_long), .rst_n_o(rst_n_o), .lowline_n(lowline_n),
    .auxfail_n(auxfail_n), .batt_on(batt_on), .backup(backup)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model, built from the requirements
  logic m_mr = 1;
  int   m_run = 0;
  int   m_age = 0;
  logic m_rst_n = 0, m_ll = 0, m_af = 0, m_batt = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_mr <= 1; m_run <= 0; m_age <= 0;
      m_rst_n <= 0; m_ll <= 0; m_af <= 0; m_batt <= 0;
    end else begin
      m_ll <= main_ok;
      m_af <= aux_ok;
      if (tick_ms) begin
        if (mr_n != m_mr && m_run + 1 == DEB_T) begin m_mr <= mr_n; m_run <= 0; end
        else if (mr_n != m_mr) m_run <= m_run + 1;
        else m_run <= 0;
      end
      if (!main_ok || !m_mr) begin
        m_rst_n <= 0; m_age <= 0;
      end else if (!m_rst_n && tick_ms) begin
        if (m_age + 1 >= (por_long ? LONG_T : SHORT_T)) begin m_rst_n <= 1; m_age <= 0; end
        else m_age <= m_age + 1;
      end
      if (main_ok) m_batt <= 0;
      else if (main_lt_batt) m_batt <= 1;
      else if (main_gt_batt) m_batt <= 0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 rst_n_o model", rst_n_o, m_rst_n);
      chk("R3 lowline_n model", lowline_n, m_ll);
      chk("R4 auxfail_n model", auxfail_n, m_af);
      chk("R7 batt_on model", batt_on, m_batt);
      chk("R8 backup model", backup, m_batt);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 190000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    step(3);
    chk("R10 reset rst_n_o", rst_n_o, 1'b0);
    chk("R10 reset lowline_n", lowline_n, 1'b0);
    chk("R10 reset auxfail_n", auxfail_n, 1'b0);
    chk("R10 reset batt_on", batt_on, 1'b0);
    chk("R10 reset backup", backup, 1'b0);
    rst = 0;
    main_ok = 1; aux_ok = 1; tick_ms = 1; por_long = 0;
    step(SHORT_T - 1);
    chk("R1 short stretch not yet", rst_n_o, 1'b0);
    chk("R3 lowline undelayed", lowline_n, 1'b1);
    step(1);
    chk("R2 short stretch release", rst_n_o, 1'b1);
    // R3 one-cycle dip, then R2 long stretch
    main_ok = 0; step(1);
    chk("R3 lowline dip", lowline_n, 1'b0);
    chk("R1 reset on dip", rst_n_o, 1'b0);
    main_ok = 1; por_long = 1;
    step(LONG_T - 1);
    chk("R2 long stretch not yet", rst_n_o, 1'b0);
    step(1);
    chk("R2 long stretch release", rst_n_o, 1'b1);
    // R9 debounce window, R5 manual reset
    mr_n = 0; step(DEB_T - 1);
    chk("R9 short press ignored", rst_n_o, 1'b1);
    mr_n = 1; step(3);
    mr_n = 0; step(DEB_T - 1);
    chk("R9 run restarted", rst_n_o, 1'b1);
    step(2);
    chk("R5 manual reset active", rst_n_o, 1'b0);
    mr_n = 1; por_long = 0;
    step(DEB_T + SHORT_T - 1);
    chk("R5 stretch after release", rst_n_o, 1'b0);
    step(1);
    chk("R5 release after stretch", rst_n_o, 1'b1);
    // R4 aux follows
    aux_ok = 0; step(1);
    chk("R4 aux fail", auxfail_n, 1'b0);
    chk("R4 reset untouched", rst_n_o, 1'b1);
    aux_ok = 1;
    // R7 hysteresis, R6 trip override
    main_ok = 0; main_lt_batt = 1; step(1);
    chk("R7 switch to battery", batt_on, 1'b1);
    chk("R8 backup set", backup, 1'b1);
    main_lt_batt = 0; step(2);
    chk("R7 hold in band", batt_on, 1'b1);
    main_gt_batt = 1; step(1);
    chk("R7 back to main", batt_on, 1'b0);
    main_gt_batt = 0; step(2);
    chk("R7 hold main in band", batt_on, 1'b0);
    main_lt_batt = 1; step(1);
    chk("R7 battery again", batt_on, 1'b1);
    main_ok = 1; step(1);
    chk("R6 main above trip forces main", batt_on, 1'b0);
    chk("R8 backup cleared", backup, 1'b0);
    main_lt_batt = 0;
    // random phase
    for (int i = 0; i < 40000; i++) begin
      tick_ms = ($urandom_range(3) != 0);
      if ($urandom_range(499) == 0) main_ok = ~main_ok;
      if ($urandom_range(19) == 0) aux_ok = ~aux_ok;
      if ($urandom_range(299) == 0) mr_n = ~mr_n;
      if ($urandom_range(999) == 0) por_long = ~por_long;
      case ($urandom_range(2))
        0: begin main_lt_batt = 1; main_gt_batt = 0; end
        1: begin main_lt_batt = 0; main_gt_batt = 1; end
        default: begin main_lt_batt = 0; main_gt_batt = 0; end
      endcase
      step(1);
    end
    finish_run();
  end
endmodule